// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each of the two ALU operands of an instruction sitting in the execute stage of a five-stage in-order integer pipeline, where the operand value should come from. The value can come from the register file read, from the ALU result held in the execute/memory pipeline register, or from the value about to be written back from the memory/writeback pipeline register. It produces a 2-bit select code per operand. It also contains the two operand multiplexers that those codes steer, so the ALU receives its final operands directly.

The unit is purely combinational. It looks at the two source register numbers of the executing instruction and at the destination number and write enable of the two older instructions further down the pipe. A stage is used as a source only if it really writes a register and that register is not register zero. When both older stages match a source, the younger result wins, because it is the more recent write.

Top module: `fwd_unit`

## Requirements
- R1: `fwd_sel_a` is 2'b10 and `alu_a` equals `em_result` whenever `em_we` is 1, `em_dst` is nonzero and `em_dst` equals `src_a_idx`.
- R2: `fwd_sel_b` is 2'b10 and `alu_b` equals `em_result` whenever `em_we` is 1, `em_dst` is nonzero and `em_dst` equals `src_b_idx`.
- R3: An operand's select is 2'b01 and its operand equals `mw_result` when `mw_we` is 1, `mw_dst` is nonzero and equals that operand's source index, and the R1/R2 condition for that operand is false.
- R4: A stage whose write enable is 0 is never chosen, whatever its destination number.
- R5: A destination number of zero is never forwarded, even with its write enable at 1.
- R6: When both stages match the same source, the execute/memory result (select 2'b10) is chosen.
- R7: In all other cases the select is 2'b00 and the operand equals the register-file read value for that operand (`rf_a_data` or `rf_b_data`); the code 2'b11 is never produced.
- R8: The outputs depend only on the present inputs and follow an input change without any clock edge.
- R9: In a chain of three back-to-back instructions that all write the same register, each dependent instruction receives the newest value written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the executing instruction |
| src_b_idx | input | 5 | Second source register number of the executing instruction |
| em_dst | input | 5 | Destination register number in the execute/memory register |
| em_we | input | 1 | Register-write enable in the execute/memory register |
| mw_dst | input | 5 | Destination register number in the memory/writeback register |
| mw_we | input | 1 | Register-write enable in the memory/writeback register |
| rf_a_data | input | 32 | Register-file read value for operand A |
| rf_b_data | input | 32 | Register-file read value for operand B |
| em_result | input | 32 | ALU result held in the execute/memory register |
| mw_result | input | 32 | Value being written back from the memory/writeback register |
| fwd_sel_a | output | 2 | Source select for operand A (00 file, 01 writeback, 10 execute/memory) |
| fwd_sel_b | output | 2 | Source select for operand B |
| alu_a | output | 32 | Final operand A |
| alu_b | output | 32 | Final operand B |

## Verification
The embedded assertions assume every input is a known value. Before the first drive, or on undriven inputs, they are skipped, since comparisons of register numbers mean nothing there. The bench drives all inputs from time zero. It sweeps every combination of write enables and of register numbers drawn from {0, 1, 2, 31}, so zero, equal, unequal and top-of-range indexes all occur. The data words are distinct constants, so any wrong multiplexer choice shows up in the operands.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a_idx,
  input  logic [REG_W-1:0]  src_b_idx,
  input  logic [REG_W-1:0]  em_dst,
  input  logic              em_we,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic              mw_we,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [DATA_W-1:0] em_result,
  input  logic [DATA_W-1:0] mw_result,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b
);

  localparam logic [1:0]       SEL_RF = 2'b00;
  localparam logic [1:0]       SEL_MW = 2'b01;
  localparam logic [1:0]       SEL_EM = 2'b10;
  localparam logic [REG_W-1:0] REG_ZERO = '0;

  logic em_live, mw_live;
  assign em_live = em_we && (em_dst != REG_ZERO);
  assign mw_live = mw_we && (mw_dst != REG_ZERO);

  logic [REG_W-1:0]  src [2];
  logic [DATA_W-1:0] rf  [2];
  assign src[0] = src_a_idx;
  assign src[1] = src_b_idx;
  assign rf[0]  = rf_a_data;
  assign rf[1]  = rf_b_data;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic              em_hit, mw_hit;
    logic [1:0]        sel;
    logic [DATA_W-1:0] val;

    assign em_hit = em_live && (em_dst == src[g]);
    assign mw_hit = mw_live && (mw_dst == src[g]);
    assign sel    = em_hit ? SEL_EM : (mw_hit ? SEL_MW : SEL_RF);
    assign val    = (sel == SEL_EM) ? em_result :
                    (sel == SEL_MW) ? mw_result : rf[g];

    always_comb begin
      if (!$isunknown({src[g], em_dst, em_we, mw_dst, mw_we, sel})) begin
        // R1 / R2 / R6: a live execute/memory match always delivers its result
        a_r1_em_wins: assert (!(em_we && em_dst != REG_ZERO && em_dst == src[g])
                              || (sel == SEL_EM && val == em_result));
        // R3: writeback path only when the younger stage does not match
        a_r3_mw_only: assert (sel != SEL_MW ||
                              (val == mw_result && mw_we && mw_dst == src[g] &&
                               !(em_we && em_dst != REG_ZERO && em_dst == src[g])));
        // R4: a non-writing stage is never a source
        a_r4_we_gate: assert ((sel != SEL_EM || em_we) && (sel != SEL_MW || mw_we));
        // R5: register zero is never forwarded
        a_r5_no_zero: assert (sel == SEL_RF || src[g] != REG_ZERO);
        // R7: default path and unused code
        a_r7_rf_path: assert (sel != 2'b11 && (sel != SEL_RF || val == rf[g]));
      end
    end
  end

  assign fwd_sel_a = g_opnd[0].sel;
  assign fwd_sel_b = g_opnd[1].sel;
  assign alu_a     = g_opnd[0].val;
  assign alu_b     = g_opnd[1].val;

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  src_a_idx = '0, src_b_idx = '0, em_dst = '0, mw_dst = '0;
  logic        em_we = 1'b0, mw_we = 1'b0;
  logic [31:0] rf_a_data = 32'hA0A0_0001, rf_b_data = 32'hB0B0_0002;
  logic [31:0] em_result = 32'hE0E0_0003, mw_result = 32'hD0D0_0004;
  logic [1:0]  fwd_sel_a, fwd_sel_b;
  logic [31:0] alu_a, alu_b;

  fwd_unit dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(logic [4:0] s);
    if (em_we && em_dst != 0 && em_dst == s) return 2'b10;
    if (mw_we && mw_dst != 0 && mw_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag(logic [4:0] s, bit is_b);
    logic [1:0] e = ref_sel(s);
    if (e == 2'b10) return (em_we && mw_we && mw_dst == s) ? "R6" : (is_b ? "R2" : "R1");
    if (e == 2'b01) return "R3";
    if ((!em_we && em_dst == s && s != 0) || (!mw_we && mw_dst == s && s != 0)) return "R4";
    if (s == 0 && ((em_we && em_dst == 0) || (mw_we && mw_dst == 0))) return "R5";
    return "R7";
  endfunction

  function automatic logic [31:0] ref_val(logic [1:0] e, logic [31:0] rfv);
    return (e == 2'b10) ? em_result : (e == 2'b01) ? mw_result : rfv;
  endfunction

  task automatic check_all();
    logic [1:0] ea = ref_sel(src_a_idx), eb = ref_sel(src_b_idx);
    chk(tag(src_a_idx, 1'b0), "sel_a", 32'(fwd_sel_a), 32'(ea));
    chk(tag(src_b_idx, 1'b1), "sel_b", 32'(fwd_sel_b), 32'(eb));
    chk(tag(src_a_idx, 1'b0), "alu_a", alu_a, ref_val(ea, rf_a_data));
    chk(tag(src_b_idx, 1'b1), "alu_b", alu_b, ref_val(eb, rf_b_data));
  endtask

  function automatic logic [4:0] idx(int i);
    return (i == 3) ? 5'd31 : 5'(i);
  endfunction

  initial begin
    @(negedge clk); #1;
    // idle state: nothing forwarded (R7)
    chk("R7", "idle sel_a", 32'(fwd_sel_a), 32'd0);
    chk("R7", "idle alu_b", alu_b, rf_b_data);

    // sweep over indexes {0,1,2,31} and all enable combinations
    for (int w = 0; w < 4; w++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int e = 0; e < 4; e++)
            for (int m = 0; m < 4; m++) begin
              @(negedge clk);
              {em_we, mw_we} = 2'(w);
              src_a_idx = idx(a); src_b_idx = idx(b);
              em_dst = idx(e); mw_dst = idx(m);
              #1 check_all();
            end

    // R6 directed: both stages write r5
    @(negedge clk);
    em_we = 1; mw_we = 1; em_dst = 5; mw_dst = 5; src_a_idx = 5; src_b_idx = 5;
    #1 chk("R6", "both sel_a", 32'(fwd_sel_a), 32'h2);
    chk("R6", "both alu_b", alu_b, em_result);

    // R8: change with no clock edge in between
    #0.5 em_we = 0;
    #0.5 chk("R8", "no-clock sel_a", 32'(fwd_sel_a), 32'h1);
    chk("R8", "no-clock alu_a", alu_a, mw_result);

    // R9: three back-to-back writes of r1 (values 10, 20, 30)
    @(negedge clk);
    src_a_idx = 1; src_b_idx = 2;
    em_we = 1; em_dst = 1; em_result = 32'd20;   // second writer in EX/MEM
    mw_we = 1; mw_dst = 1; mw_result = 32'd10;   // first writer in MEM/WB
    #1 chk("R9", "third gets second", alu_a, 32'd20);
    @(negedge clk);
    em_result = 32'd30; mw_result = 32'd20;      // chain advanced one stage
    #1 chk("R9", "fourth gets third", alu_a, 32'd30);
    chk("R9", "unrelated b", alu_b, rf_b_data);
    @(negedge clk);
    em_we = 0; mw_result = 32'd30;               // only third writer remains
    #1 chk("R9", "fifth gets third", alu_a, 32'd30);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=running expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule